// File: doc/BRIEF.md
# Auto-ranging frequency measurement sequencer

This block drives the control side of an on-chip frequency meter to measure one selected clock source with the best resolution that the meter's 16-bit counter allows. A one-cycle `start_i` pulse latches a source index. The sequencer then runs a series of measurement attempts. The first attempt uses the longest gate window. If the meter reports a saturated count, the next attempt uses a window that is one step shorter. The search stops at the first count that did not saturate.

Each attempt is a fixed series of writes to the meter's control word. The sequencer then polls the meter's busy line on a slow fixed period. After the meter finishes, it clears the enable bit and then reads the count. From the count and the gate length, two restoring dividers that run in parallel produce the rounded frequency in hertz and the precision of that reading. If no window length avoids saturation, a range error ends the search. If busy stays high too long, a timeout error aborts the search.

Top module: `freq_autorange`

## Requirements
- R1: The first attempt after `start_i` uses a gate length of `GATE_MAX` (640) ticks. The length field `mtr_len_o` carries the gate length minus one (639).
- R2: Each attempt issues exactly four control writes (`mtr_wr_o` pulses) in this order: an all-zero word; the length field alone; the length plus the latched source in `mtr_src_o`; then the same word with `mtr_run_o` and `mtr_en_o` both set.
- R3: A count equal to all ones (0xFFFF) is an overflow. After an overflow the next attempt's gate length is 32 ticks shorter. The first count below 0xFFFF ends the search with that gate length.
- R4: Busy is sampled once every `POLL_CYC` cycles. After busy is seen low, a write with `mtr_en_o`=0 comes before the one-cycle read strobe `mtr_rd_o`. Busy is low at the read.
- R5: `freq_o` = round-half-up(count × 1,000,000 / gate length).
- R6: `prec_o` = floor(2,000,000 / gate length), using the gate length of the accepted attempt.
- R7: On success `done_o` is high for exactly one cycle, with `freq_o` and `prec_o` already valid. At most one of `done_o`, `err_range_o` and `err_tmo_o` is high in any cycle.
- R8: If every length from 640 down to 32 overflows (20 attempts), `err_range_o` pulses for one cycle with `freq_o` and `prec_o` at zero, and no further attempt starts.
- R9: If busy is still high at `TMO_POLLS` consecutive samples, `err_tmo_o` pulses for one cycle with `freq_o` and `prec_o` at zero, and the search is abandoned with no further attempt.
- R10: `start_i` pulses that arrive while a search is in progress are ignored. They change neither the source index nor the number of attempts.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| src_i | input | SRC_W | Source index to measure |
| mtr_wr_o | output | 1 | Meter control-word write strobe |
| mtr_len_o | output | LEN_W | Gate length minus one |
| mtr_src_o | output | SRC_W | Source select field |
| mtr_run_o | output | 1 | Run bit |
| mtr_en_o | output | 1 | Enable bit |
| mtr_rd_o | output | 1 | Count read strobe |
| mtr_busy_i | input | 1 | Meter busy |
| mtr_count_i | input | CNT_W | Meter count result |
| done_o | output | 1 | Result valid pulse |
| err_range_o | output | 1 | All gate lengths overflowed |
| err_tmo_o | output | 1 | Busy timeout |
| freq_o | output | OUT_W | Frequency in Hz |
| prec_o | output | OUT_W | Precision in Hz |

## Verification
A wrong gate register or step shows up at the next run write. That write then carries a length outside the 32-tick ladder, or one that does not match the overflow history, one attempt after the fault. A broken write order or a stale enable shows up within the same attempt, because the bench's meter model checks each run write against the three writes before it, and checks each read strobe against the last write. Divider or rounding faults appear only in the `freq_o` and `prec_o` values at `done_o`, roughly 40 cycles after the read. A wrong poll or timeout count shifts the moment `err_tmo_o` fires, or makes it fire when it should not.

// File: rtl/freq_autorange_pkg.sv
package freq_autorange_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_LEN, S_SRC, S_RUN, S_WAIT, S_DIS, S_READ, S_EVAL, S_DIV
  } seq_st_e;
endpackage

// File: rtl/freq_autorange_div.sv
module freq_autorange_div #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             vld_o
);
  localparam int IT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [IT_W-1:0]  it_q;
  logic             run_q, vld_q;
  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             take;

  assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign take    = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      it_q  <= '0;
      run_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (go_i) begin
      rem_q <= '0;
      den_q <= den_i;
      quo_q <= num_i;
      it_q  <= IT_W'(NUM_W);
      run_q <= 1'b1;
      vld_q <= 1'b0;
    end else if (run_q) begin
      if (take) begin
        rem_q <= rem_sub[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], 1'b0};
      end
      it_q <= it_q - IT_W'(1);
      if (it_q == IT_W'(1)) begin
        run_q <= 1'b0;
        vld_q <= 1'b1;
      end
    end
  end

  assign quo_o = quo_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/freq_autorange_poll.sv
module freq_autorange_poll #(
  parameter int POLL_CYC  = 1250,
  parameter int TMO_POLLS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o,
  output logic last_o
);
  localparam int TW = $clog2(POLL_CYC + 1);
  localparam int PW = $clog2(TMO_POLLS + 1);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] polls_q;

  assign tick_o = en_i && (tmr_q == TW'(POLL_CYC - 1));
  assign last_o = polls_q == PW'(TMO_POLLS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      polls_q <= '0;
    end else if (clr_i) begin
      tmr_q   <= '0;
      polls_q <= '0;
    end else if (en_i) begin
      if (tick_o) begin
        tmr_q   <= '0;
        polls_q <= polls_q + PW'(1);
      end else begin
        tmr_q <= tmr_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/freq_autorange.sv
module freq_autorange
  import freq_autorange_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LEN_W      = 16,
  parameter int SRC_W      = 7,
  parameter int OUT_W      = 32,
  parameter int GATE_MAX   = 640,
  parameter int GATE_STEP  = 32,
  parameter int GATE_MIN   = 32,
  parameter int SCALE      = 1000000,
  parameter int PREC_SCALE = 2000000,
  parameter int POLL_CYC   = 1250,
  parameter int TMO_POLLS  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             mtr_wr_o,
  output logic [LEN_W-1:0] mtr_len_o,
  output logic [SRC_W-1:0] mtr_src_o,
  output logic             mtr_run_o,
  output logic             mtr_en_o,
  output logic             mtr_rd_o,
  input  logic             mtr_busy_i,
  input  logic [CNT_W-1:0] mtr_count_i,
  output logic             done_o,
  output logic             err_range_o,
  output logic             err_tmo_o,
  output logic [OUT_W-1:0] freq_o,
  output logic [OUT_W-1:0] prec_o
);
  localparam int SCL_W = $clog2(PREC_SCALE + 1);
  localparam int NUM_W = CNT_W + SCL_W;

  seq_st_e          st_q;
  logic [SRC_W-1:0] src_q;
  logic [LEN_W-1:0] gate_q;
  logic [CNT_W-1:0] cnt_q;
  logic             div_go_q;
  logic             tick, last_poll;
  logic             ovf, last_gate;
  logic [NUM_W-1:0] num_f, num_p, quo_f, quo_p;
  logic             vld_f, vld_p;

  assign ovf       = mtr_count_i == {CNT_W{1'b1}};
  assign last_gate = gate_q < LEN_W'(GATE_MIN + GATE_STEP);
  // round half up: add half the divisor before dividing
  assign num_f = NUM_W'(cnt_q) * NUM_W'(SCALE) + NUM_W'(gate_q >> 1);
  assign num_p = NUM_W'(PREC_SCALE);

  freq_autorange_poll #(
    .POLL_CYC (POLL_CYC),
    .TMO_POLLS(TMO_POLLS)
  ) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == S_RUN),
    .en_i  (st_q == S_WAIT),
    .tick_o(tick),
    .last_o(last_poll)
  );

  freq_autorange_div #(.NUM_W(NUM_W), .DEN_W(LEN_W)) u_div_freq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go_q),
    .num_i (num_f),
    .den_i (gate_q),
    .quo_o (quo_f),
    .vld_o (vld_f)
  );

  freq_autorange_div #(.NUM_W(NUM_W), .DEN_W(LEN_W)) u_div_prec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go_q),
    .num_i (num_p),
    .den_i (gate_q),
    .quo_o (quo_p),
    .vld_o (vld_p)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      src_q       <= '0;
      gate_q      <= '0;
      cnt_q       <= '0;
      div_go_q    <= 1'b0;
      mtr_wr_o    <= 1'b0;
      mtr_len_o   <= '0;
      mtr_src_o   <= '0;
      mtr_run_o   <= 1'b0;
      mtr_en_o    <= 1'b0;
      mtr_rd_o    <= 1'b0;
      done_o      <= 1'b0;
      err_range_o <= 1'b0;
      err_tmo_o   <= 1'b0;
      freq_o      <= '0;
      prec_o      <= '0;
    end else begin
      mtr_wr_o    <= 1'b0;
      mtr_rd_o    <= 1'b0;
      done_o      <= 1'b0;
      err_range_o <= 1'b0;
      err_tmo_o   <= 1'b0;
      div_go_q    <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          src_q  <= src_i;
          gate_q <= LEN_W'(GATE_MAX);
          st_q   <= S_CLR;
        end
        S_CLR: begin
          mtr_wr_o  <= 1'b1;
          mtr_len_o <= '0;
          mtr_src_o <= '0;
          mtr_run_o <= 1'b0;
          mtr_en_o  <= 1'b0;
          st_q      <= S_LEN;
        end
        S_LEN: begin
          mtr_wr_o  <= 1'b1;
          mtr_len_o <= gate_q - LEN_W'(1);
          st_q      <= S_SRC;
        end
        S_SRC: begin
          mtr_wr_o  <= 1'b1;
          mtr_src_o <= src_q;
          st_q      <= S_RUN;
        end
        S_RUN: begin
          mtr_wr_o  <= 1'b1;
          mtr_run_o <= 1'b1;
          mtr_en_o  <= 1'b1;
          st_q      <= S_WAIT;
        end
        S_WAIT: if (tick) begin
          if (!mtr_busy_i) begin
            st_q <= S_DIS;
          end else if (last_poll) begin
            err_tmo_o <= 1'b1;
            freq_o    <= '0;
            prec_o    <= '0;
            st_q      <= S_IDLE;
          end
        end
        S_DIS: begin
          mtr_wr_o <= 1'b1;
          mtr_en_o <= 1'b0;
          st_q     <= S_READ;
        end
        S_READ: begin
          mtr_rd_o <= 1'b1;
          st_q     <= S_EVAL;
        end
        S_EVAL: begin
          if (!ovf) begin
            cnt_q    <= mtr_count_i;
            div_go_q <= 1'b1;
            st_q     <= S_DIV;
          end else if (last_gate) begin
            err_range_o <= 1'b1;
            freq_o      <= '0;
            prec_o      <= '0;
            st_q        <= S_IDLE;
          end else begin
            gate_q <= gate_q - LEN_W'(GATE_STEP);
            st_q   <= S_CLR;
          end
        end
        S_DIV: if (!div_go_q && vld_f && vld_p) begin
          freq_o <= OUT_W'(quo_f);
          prec_o <= OUT_W'(quo_p);
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/freq_autorange_chk.sv
module freq_autorange_chk #(
  parameter int LEN_W      = 16,
  parameter int OUT_W      = 32,
  parameter int GATE_MAX   = 640,
  parameter int GATE_STEP  = 32,
  parameter int GATE_MIN   = 32,
  parameter int PREC_SCALE = 2000000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             err_range_o,
  input logic             err_tmo_o,
  input logic [OUT_W-1:0] freq_o,
  input logic [OUT_W-1:0] prec_o,
  input logic             mtr_wr_o,
  input logic             mtr_rd_o,
  input logic [LEN_W-1:0] mtr_len_o,
  input logic             mtr_run_o,
  input logic             mtr_en_o,
  input logic             mtr_busy_i
);
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_range_o, err_tmo_o}));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_gate_ladder_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtr_wr_o && mtr_run_o && mtr_en_o) |->
      (((int'(mtr_len_o) + 1) % GATE_STEP) == 0) &&
      (int'(mtr_len_o) + 1 <= GATE_MAX) && (int'(mtr_len_o) + 1 >= GATE_MIN));

  p_en_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtr_wr_o && mtr_en_o) |-> mtr_run_o);

  p_read_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtr_rd_o |-> (!mtr_en_o && !mtr_busy_i));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_range_o || err_tmo_o) |-> (freq_o == '0 && prec_o == '0));

  p_prec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prec_o == OUT_W'(PREC_SCALE / (int'(mtr_len_o) + 1))));
endmodule

bind freq_autorange freq_autorange_chk #(
  .LEN_W     (LEN_W),
  .OUT_W     (OUT_W),
  .GATE_MAX  (GATE_MAX),
  .GATE_STEP (GATE_STEP),
  .GATE_MIN  (GATE_MIN),
  .PREC_SCALE(PREC_SCALE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .err_range_o(err_range_o),
  .err_tmo_o  (err_tmo_o),
  .freq_o     (freq_o),
  .prec_o     (prec_o),
  .mtr_wr_o   (mtr_wr_o),
  .mtr_rd_o   (mtr_rd_o),
  .mtr_len_o  (mtr_len_o),
  .mtr_run_o  (mtr_run_o),
  .mtr_en_o   (mtr_en_o),
  .mtr_busy_i (mtr_busy_i)
);

// File: tb/freq_autorange_tb.sv
`timescale 1ns/1ps
module freq_autorange_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  src = '0;
  logic        m_wr, m_run, m_en, m_rd;
  logic [15:0] m_len;
  logic [6:0]  m_src;
  logic        m_busy;
  logic [15:0] m_cnt;
  logic        done, e_rng, e_tmo;
  logic [31:0] freq, prec;

  always #4 clk = ~clk;

  freq_autorange #(.POLL_CYC(4), .TMO_POLLS(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_i(src),
    .mtr_wr_o(m_wr), .mtr_len_o(m_len), .mtr_src_o(m_src),
    .mtr_run_o(m_run), .mtr_en_o(m_en), .mtr_rd_o(m_rd),
    .mtr_busy_i(m_busy), .mtr_count_i(m_cnt),
    .done_o(done), .err_range_o(e_rng), .err_tmo_o(e_tmo),
    .freq_o(freq), .prec_o(prec)
  );

  int vectors = 0, fails = 0;
  // meter model configuration
  longint rate_num = 1, rate_den = 1;
  int     lat = 10;
  bit     stuck = 1'b0;
  logic [6:0] exp_src = '0;

  // meter model state
  int att = 0, seq_bad = 0, src_bad = 0, rd_bad = 0, bcnt = 0;
  int gates [0:255];
  logic [24:0] h0 = '0, h1 = '0, h2 = '0;
  logic        busy_r = 1'b0;
  logic [15:0] cnt_r = '0;
  assign m_busy = busy_r;
  assign m_cnt  = cnt_r;

  function automatic longint model_cnt(input longint g);
    longint c;
    c = (g * rate_num) / rate_den;
    return (c >= 65535) ? 65535 : c;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_wr) begin
        if (m_run && m_en) begin
          if (!(h2 == '0 && h1 == {m_len, 7'd0, 2'b00} && h0 == {m_len, m_src, 2'b00}))
            seq_bad <= seq_bad + 1;
          if (m_src != exp_src) src_bad <= src_bad + 1;
          gates[att % 256] <= int'(m_len) + 1;
          att    <= att + 1;
          busy_r <= 1'b1;
          bcnt   <= lat;
          cnt_r  <= 16'(model_cnt(longint'(m_len) + 1));
        end
        h2 <= h1; h1 <= h0; h0 <= {m_len, m_src, m_run, m_en};
      end
      if (m_rd && h0[0]) rd_bad <= rd_bad + 1;
      if (busy_r && !stuck) begin
        if (bcnt == 0) busy_r <= 1'b0;
        else bcnt <= bcnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_gate();
    for (longint g = 640; g >= 32; g -= 32)
      if (model_cnt(g) < 65535) return g;
    return 0;
  endfunction

  // kind: 1 done, 2 range error, 3 timeout, 0 none
  task automatic measure(input logic [6:0] s, input int poke_at, output int kind, output int n_att);
    int base;
    base = att;
    kind = 0;
    exp_src = s;
    @(negedge clk); src = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (poke_at > 0 && i == poke_at) begin src = 7'd5; start = 1'b1; end
      else if (poke_at > 0 && i == poke_at + 1) begin start = 1'b0; src = s; end
      if (done || e_rng || e_tmo) begin
        chk((32'(done) + 32'(e_rng) + 32'(e_tmo)) == 1, "R7 one flag", 32'(done) + 32'(e_rng) + 32'(e_tmo), 1);
        kind = done ? 1 : (e_rng ? 2 : 3);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    chk(!done && !e_rng && !e_tmo, "R7 single cycle", 32'(done | e_rng | e_tmo), 0);
    n_att = att - base;
  endtask

  task automatic t_reset();
    chk(m_wr == 0 && m_rd == 0 && m_run == 0 && m_en == 0, "R11 meter ctl", {m_wr, m_rd, m_run, m_en}, 0);
    chk(done == 0 && e_rng == 0 && e_tmo == 0, "R11 flags", {done, e_rng, e_tmo}, 0);
    chk(freq == 0 && prec == 0 && m_len == 0, "R11 data", freq, 0);
  endtask

  task automatic t_good(input string name, input longint rn, input longint rd, input logic [6:0] s);
    int kind, n, sb, ssb, rb, base;
    longint g, c, ef, ep;
    rate_num = rn; rate_den = rd; lat = 10; stuck = 0;
    sb = seq_bad; ssb = src_bad; rb = rd_bad; base = att;
    g  = exp_gate();
    c  = model_cnt(g);
    ef = (c * 1000000 + g / 2) / g;
    ep = 2000000 / g;
    measure(s, 0, kind, n);
    chk(kind == 1, {name, " R7 done"}, kind, 1);
    chk(gates[base % 256] == 640, {name, " R1 first gate"}, gates[base % 256], 640);
    chk(n == int'((640 - g) / 32 + 1), {name, " R3 attempts"}, n, (640 - g) / 32 + 1);
    chk(gates[(base + n - 1) % 256] == g, {name, " R3 final gate"}, gates[(base + n - 1) % 256], g);
    chk(freq == 32'(ef), {name, " R5 freq"}, freq, ef);
    chk(prec == 32'(ep), {name, " R6 prec"}, prec, ep);
    chk(seq_bad == sb, {name, " R2 write order"}, seq_bad - sb, 0);
    chk(src_bad == ssb, {name, " R2 source field"}, src_bad - ssb, 0);
    chk(rd_bad == rb, {name, " R4 enable off before read"}, rd_bad - rb, 0);
  endtask

  task automatic t_range();
    int kind, n, base;
    rate_num = 3000; rate_den = 1; lat = 10; stuck = 0;
    base = att;
    measure(7'd9, 0, kind, n);
    chk(kind == 2, "R8 range error", kind, 2);
    chk(n == 20, "R8 attempts", n, 20);
    for (int k = 0; k < 20; k++)
      chk(gates[(base + k) % 256] == 640 - 32 * k, "R3 ladder", gates[(base + k) % 256], 640 - 32 * k);
    chk(freq == 0 && prec == 0, "R8 zero outputs", freq, 0);
    repeat (30) @(negedge clk);
    chk(att - base == 20, "R8 no restart", att - base, 20);
  endtask

  task automatic t_timeout();
    int kind, n, base;
    rate_num = 50; rate_den = 1; lat = 10; stuck = 1;
    base = att;
    measure(7'd2, 0, kind, n);
    chk(kind == 3, "R9 timeout error", kind, 3);
    chk(n == 1, "R9 single attempt", n, 1);
    chk(freq == 0 && prec == 0, "R9 zero outputs", freq, 0);
    repeat (40) @(negedge clk);
    chk(att - base == 1, "R9 no retry", att - base, 1);
    stuck = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_short_timeout_ok();
    int kind, n;
    // busy longer than one poll period but well inside the limit
    rate_num = 50; rate_den = 1; lat = 20; stuck = 0;
    measure(7'd4, 0, kind, n);
    chk(kind == 1, "R4 slow busy still completes", kind, 1);
    chk(freq == 50000000, "R4 slow busy freq", freq, 50000000);
  endtask

  task automatic t_ignore();
    int kind, n, ssb, base;
    rate_num = 150; rate_den = 1; lat = 10; stuck = 0;
    ssb = src_bad; base = att;
    measure(7'd3, 40, kind, n);
    chk(kind == 1, "R10 done", kind, 1);
    chk(n == 8, "R10 attempts unchanged", n, 8);
    chk(src_bad == ssb, "R10 source unchanged", src_bad - ssb, 0);
    repeat (40) @(negedge clk);
    chk(att - base == 8, "R10 no extra search", att - base, 8);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_good("single", 50, 1, 7'd1);      // 640 ticks, exact
    t_good("stepdown", 150, 1, 7'd6);   // 8 attempts, gate 416
    t_good("round", 7, 3, 7'd11);       // fractional result rounds up
    t_good("allones", 65535, 640, 7'd0);// count 0xFFFF at 640 is overflow
    t_good("floor", 3000, 1500, 7'd127);// large source index
    t_range();
    t_timeout();
    t_short_timeout_ok();
    t_ignore();
    finish_run();
  end
endmodule